// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

One timer channel that holds a 32-bit count and steps it down by one on each tick of the selected rate. When the count reaches zero it waits at zero for one more tick and then reloads from a programmable reload register, so it runs as a periodic timer. Two match registers are compared against the falling count. They can be written in any order: the larger value is reached first, then the smaller one, then zero. Each interrupt event inverts the level of the interrupt line rather than sending a pulse, so the receiver detects edges.

Software reaches the channel through a word write port with a 2-bit register select. The enable, tick-select and zero-interrupt control bits are plain level inputs. The live count is brought out on `count_o` so it can be read back. Two tick strobes come in from outside: a fast system tick (about 24 MHz) and a slow external tick (about 1 MHz). Each strobe is high for one clock cycle per tick.

Top module: `rld_down_timer`

## Requirements
- R1: After reset the count, the reload value, both match values and the interrupt level are all zero.
- R2: With `clk_sel_i`=0 only `tick_fast_i` advances the channel. With `clk_sel_i`=1 only `tick_ext_i` advances it. A strobe that is not selected changes neither the count nor `irq_o`.
- R3: While enabled, each selected tick with a nonzero count lowers `count_o` by exactly one. The change is visible after that clock edge.
- R4: A selected tick while the count is zero loads the reload value. The count therefore rests at zero for one tick.
- R5: A tick that brings the count down to a nonzero value equal to either match register inverts `irq_o`. The inversion happens once even when both match registers hold that value. The comparison uses the match values held before any write in the same cycle.
- R6: A tick that brings the count from 1 to 0 inverts `irq_o` only if `ovf_irq_en_i`=1 or at least one match register holds zero.
- R7: A write with `wr_sel_i`=0 (status) loads `wr_data_i` into the count if the channel is enabled. If the channel is disabled, the write is ignored.
- R8: A write with `wr_sel_i`=1 always updates the reload register. It also loads the count, but only when the channel is enabled, the old reload value was zero and the new value is nonzero. `wr_sel_i`=2 writes match A and `wr_sel_i`=3 writes match B.
- R9: In the first enabled cycle after a disabled one, the count loads the reload value. While disabled, `count_o` and `irq_o` hold.
- R10: With a reload value of zero, a count at zero stays at zero and produces no events.
- R11: In a single cycle, at most one update is applied to the count. The priority is: enable rising > status write > reload start > tick. A tick that loses to a load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 status, 1 reload, 2 match A, 3 match B |
| wr_data_i | input | 32 | Write data |
| enable_i | input | 1 | Channel enable |
| clk_sel_i | input | 1 | 0 fast tick, 1 external tick |
| ovf_irq_en_i | input | 1 | Treat reaching zero as an event |
| tick_fast_i | input | 1 | Fast tick strobe |
| tick_ext_i | input | 1 | External tick strobe |
| count_o | output | 32 | Live count |
| irq_o | output | 1 | Level-toggling interrupt |

## Verification
A corrupted count shows up on `count_o` at the next clock edge. A wrong decrement, reload or load priority is therefore caught the cycle it happens. A wrong match or zero-event decision causes `irq_o` to go out of phase on the tick where the comparison is made. Because the line toggles, a single missed or extra event leaves the level inverted from then on. Every later cycle then shows the error.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_MATCH_A = 2'd2,
    SEL_MATCH_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
  input  logic fast_i,
  input  logic ext_i,
  input  logic sel_i,
  output logic tick_o
);
  assign tick_o = sel_i ? ext_i : fast_i;
endmodule

// File: rtl/tmr_match_eval.sv
module tmr_match_eval #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] match_a_i,
  input  logic [CNT_W-1:0] match_b_i,
  input  logic             ovf_en_i,
  output logic             hit_o
);
  logic a_zero, b_zero, nxt_zero;
  assign a_zero   = (match_a_i == '0);
  assign b_zero   = (match_b_i == '0);
  assign nxt_zero = (nxt_i == '0);
  // zero landing handled separately so a zero match never fires twice
  assign hit_o = (!a_zero && nxt_i == match_a_i)
               | (!b_zero && nxt_i == match_b_i)
               | (nxt_zero && (ovf_en_i | a_zero | b_zero));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  assign zero_o  = (cnt_q == '0);
  assign nxt_o   = cnt_q - CNT_W'(1);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= zero_o ? reload_i : nxt_o;
  end
endmodule

// File: rtl/rld_down_timer.sv
module rld_down_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             enable_i,
  input  logic             clk_sel_i,
  input  logic             ovf_irq_en_i,
  input  logic             tick_fast_i,
  input  logic             tick_ext_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] reload_q, match_a_q, match_b_q, nxt;
  logic             en_q, irq_q, tick, hit, at_zero;
  logic             en_rise, wr_status, wr_start, load, step, evt;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(wr_sel_i);

  tmr_tick_sel u_tick (
    .fast_i (tick_fast_i),
    .ext_i  (tick_ext_i),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  assign en_rise   = enable_i & ~en_q;
  assign wr_status = wr_en_i & (sel == SEL_STATUS) & enable_i;
  assign wr_start  = wr_en_i & (sel == SEL_RELOAD) & enable_i
                   & (reload_q == '0) & (wr_data_i != '0);
  assign load      = en_rise | wr_status | wr_start;
  assign step      = enable_i & tick & ~load;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (en_rise ? reload_q : wr_data_i),
    .step_i     (step),
    .reload_i   (reload_q),
    .count_o    (count_o),
    .nxt_o      (nxt),
    .zero_o     (at_zero)
  );

  tmr_match_eval #(.CNT_W(CNT_W)) u_match (
    .nxt_i     (nxt),
    .match_a_i (match_a_q),
    .match_b_i (match_b_q),
    .ovf_en_i  (ovf_irq_en_i),
    .hit_o     (hit)
  );

  assign evt = step & ~at_zero & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q  <= '0;
      match_a_q <= '0;
      match_b_q <= '0;
      en_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      en_q  <= enable_i;
      irq_q <= irq_q ^ evt;
      if (wr_en_i) begin
        unique case (sel)
          SEL_RELOAD:  reload_q  <= wr_data_i;
          SEL_MATCH_A: match_a_q <= wr_data_i;
          SEL_MATCH_B: match_b_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rld_down_timer_chk.sv
module rld_down_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             en_q,
  input logic             tick,
  input logic             step,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o
);
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(count_o) && $stable(irq_o)); // R9
  AST_RISE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !en_q) |=> count_o == $past(reload_q)); // R9
  AST_STEP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && count_o != '0) |=> count_o == $past(count_o) - CNT_W'(1)); // R3
  AST_WRAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && count_o == '0) |=> count_o == $past(reload_q)); // R4
  AST_UNSEL_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && en_q && !tick && !wr_en_i) |=> $stable(count_o) && $stable(irq_o)); // R2
  AST_STATUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && en_q && wr_en_i && wr_sel_i == 2'd0) |=> count_o == $past(wr_data_i)); // R7
  AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && reload_q == '0 && count_o == '0) |=> $stable(irq_o) && count_o == '0); // R10
endmodule

bind rld_down_timer rld_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .en_q      (en_q),
  .tick      (tick),
  .step      (step),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .reload_q  (reload_q),
  .count_o   (count_o),
  .irq_o     (irq_o)
);

// File: tb/tb_rld_down_timer.sv
module tb_rld_down_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, en = 0, cs = 0, ov = 0, tf = 0, te = 0;
  logic [1:0]  ws = 0;
  logic [31:0] wd = 0;
  logic [31:0] count;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  logic [31:0] m_cnt = 0, m_rel = 0, m_ma = 0, m_mb = 0;
  logic        m_irq = 0, m_enq = 0;

  always #5 clk = ~clk;

  rld_down_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(ws), .wr_data_i(wd),
    .enable_i(en), .clk_sel_i(cs), .ovf_irq_en_i(ov), .tick_fast_i(tf),
    .tick_ext_i(te), .count_o(count), .irq_o(irq)
  );

  function automatic logic ev_hit(logic [31:0] n);
    return (m_ma != 0 && n == m_ma) || (m_mb != 0 && n == m_mb) ||
           (n == 0 && (ov || m_ma == 0 || m_mb == 0));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // model update from the inputs seen at the edge
  task automatic model_step();
    logic tk;
    tk = cs ? te : tf;
    if (en && !m_enq) m_cnt = m_rel;
    else if (wr_en && ws == 0 && en) m_cnt = wd;
    else if (wr_en && ws == 1 && en && m_rel == 0 && wd != 0) m_cnt = wd;
    else if (en && tk) begin
      if (m_cnt == 0) m_cnt = m_rel;
      else begin
        if (ev_hit(m_cnt - 1)) m_irq = ~m_irq;
        m_cnt = m_cnt - 1;
      end
    end
    if (wr_en) case (ws)
      2'd1: m_rel = wd;
      2'd2: m_ma  = wd;
      2'd3: m_mb  = wd;
      default: ;
    endcase
    m_enq = en;
  endtask

  task automatic cyc(string tag, logic e, logic c, logic o, logic f, logic x,
                     logic w, logic [1:0] s, logic [31:0] d);
    en = e; cs = c; ov = o; tf = f; te = x; wr_en = w; ws = s; wd = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " count"}, count, m_cnt);
    check({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    // R10 zero reload: enabled ticks stay at zero, no events
    for (int i = 0; i < 3; i++) cyc("R10", 1, 0, 1, 1, 0, 0, 0, 0);
    // R8 reload 0->nonzero while enabled starts count
    cyc("R8", 1, 0, 0, 0, 0, 1, 1, 6);
    cyc("R8", 1, 0, 0, 1, 0, 1, 1, 9);   // reload update only, tick proceeds
    // R7 status write while disabled ignored
    cyc("R9", 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 1, 0, 3);
    // matches written in reverse order
    cyc("R5", 0, 0, 0, 0, 0, 1, 3, 2);
    cyc("R5", 0, 0, 0, 0, 0, 1, 2, 6);
    cyc("R9", 1, 0, 0, 1, 0, 0, 0, 0);   // rise loads 9, tick dropped
    // R2 unselected strobes
    cyc("R2", 1, 1, 0, 1, 0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 0, 1, 0, 0, 0);
    // R5/R6/R4 full period with zero event disabled
    for (int i = 0; i < 11; i++) cyc("R5", 1, 1, 0, 0, 1, 0, 0, 0);
    // R6 zero event with overflow enable
    for (int i = 0; i < 11; i++) cyc("R6", 1, 0, 1, 1, 0, 0, 0, 0);
    // R5 equal matches toggle once
    cyc("R5", 1, 0, 0, 0, 0, 1, 2, 4);
    cyc("R5", 1, 0, 0, 0, 0, 1, 3, 4);
    for (int i = 0; i < 11; i++) cyc("R5", 1, 0, 0, 1, 0, 0, 0, 0);
    // R6 a zero match makes zero an event
    cyc("R6", 1, 0, 0, 0, 0, 1, 2, 0);
    for (int i = 0; i < 11; i++) cyc("R6", 1, 0, 0, 1, 0, 0, 0, 0);
    // R11 priority: status write beats tick; rise beats status write
    cyc("R11", 1, 0, 0, 1, 0, 1, 0, 2);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R11", 1, 0, 0, 1, 0, 1, 0, 7);
    cyc("R4", 1, 0, 0, 1, 0, 1, 0, 1);
    cyc("R4", 1, 0, 0, 1, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 1, 0, 0, 0, 0);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic e, c, o, w;
      e = ($urandom % 40 == 0) ? ~en : en;
      c = ($urandom % 30 == 0) ? ~cs : cs;
      o = ($urandom % 20 == 0) ? ~ov : ov;
      w = ($urandom % 12 == 0);
      cyc("R3", e, c, o, ($urandom % 2), ($urandom % 3 == 0), w,
          2'($urandom % 4), $urandom % 10);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule